// File: doc/BRIEF.md
# Split Cache Control Register Unit

This block holds the control state for a pair of independent caches, one for instructions and one for data. A supervisor-level register port gives access to two registers. The 32-bit control register carries a separate field group for each cache. The address register names a single cache line. The block turns control writes into steady level outputs for each cache: enable, freeze and burst-enable, plus write-allocate for the data cache. The command bits in a write become one-cycle invalidate strobes.

The block also owns the valid bit of every line in both caches. A cache controller asks to allocate a line through a request and an index. The request sets that line's valid bit only when the cache is enabled and not frozen. Invalidate commands clear either the whole array or the single line that the address register selects, and they take effect whether or not the cache is frozen. A hardware reset returns the block to a fully disabled and empty state.

Top module: `split_cache_ctrl`

## Requirements
- R1: A control write (`reg_we`=1, `reg_sel`=0) stores the level bits, and reading with `reg_sel`=0 returns them at these positions: instruction enable bit 0, instruction freeze bit 1, instruction burst bit 4, data enable bit 8, data freeze bit 9, data burst bit 12, data write-allocate bit 13.
- R2: Bits 31:14 and 7:5 of the control register always read as zero, and values written to them change nothing.
- R3: The command bits 2, 3, 10 and 11 are not stored and always read as zero.
- R4: After reset the control register, the address register, all level outputs, all strobes and every valid bit are zero.
- R5: A control write with bit 3 set pulses `ic_inv_all` high for exactly the one cycle after the write edge. On the next edge every instruction valid bit clears, and the data valid bits are untouched.
- R6: A control write with bit 11 set does the same for the data cache through `dc_inv_all`. Bits 3 and 11 set together clear both caches.
- R7: A control write with bit 2 (instruction) or bit 10 (data) set pulses the matching single-line strobe for one cycle. It then clears only the valid bit indexed by address-register bits 7:4 as they were at the write.
- R8: An allocation request sets valid bit `idx` of its cache on the next edge only when that cache's enable is 1 and its freeze is 0. Otherwise no valid bit rises.
- R9: While freeze is set, allocation requests are blocked, but whole-cache and single-line invalidates still clear valid bits.
- R10: An invalidate and an allocation that reach a cache on the same edge leave the affected line invalid.
- R11: An address write (`reg_we`=1, `reg_sel`=1) stores all 32 bits, and reading with `reg_sel`=1 returns them.
- R12: The level outputs `ic_enable`, `ic_freeze`, `ic_burst`, `dc_enable`, `dc_freeze`, `dc_burst` and `dc_wr_alloc` follow the stored control bits from the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the address register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ic_alloc_req | input | 1 | Instruction cache line allocation request |
| ic_alloc_idx | input | IDX_W | Instruction line index to allocate |
| dc_alloc_req | input | 1 | Data cache line allocation request |
| dc_alloc_idx | input | IDX_W | Data line index to allocate |
| ic_enable | output | 1 | Instruction cache enable level |
| ic_freeze | output | 1 | Instruction cache freeze level |
| ic_burst | output | 1 | Instruction burst-fill enable level |
| dc_enable | output | 1 | Data cache enable level |
| dc_freeze | output | 1 | Data cache freeze level |
| dc_burst | output | 1 | Data burst-fill enable level |
| dc_wr_alloc | output | 1 | Data write-allocate level |
| ic_inv_all | output | 1 | One-cycle whole instruction cache invalidate strobe |
| dc_inv_all | output | 1 | One-cycle whole data cache invalidate strobe |
| ic_inv_one | output | 1 | One-cycle instruction single-line invalidate strobe |
| dc_inv_one | output | 1 | One-cycle data single-line invalidate strobe |
| ic_valid | output | LINES | Instruction valid bits |
| dc_valid | output | LINES | Data valid bits |

## Verification
The bench targets several ways the design could go wrong. A design that stored a command bit would read it back as one and would clear the cache again on later writes. A design that mixed up the two field groups would clear or enable the wrong cache. A single-line clear that decoded the wrong address bits, or that took the index after a later address write, would clear a neighbouring line. The bench also checks freeze. A freeze that also blocked invalidates would leave stale lines valid. A freeze that did not block allocation, or an allocation that beat a same-edge invalidate, would leave a line valid after the clear.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int CTRL_W   = 32;
  localparam int DC_BASE  = 8;
  localparam int OFS_EN   = 0;
  localparam int OFS_FRZ  = 1;
  localparam int OFS_ONE  = 2;
  localparam int OFS_ALL  = 3;
  localparam int OFS_BRST = 4;
  localparam int BIT_WALC = 13;

  typedef struct packed {
    logic en;
    logic frz;
    logic burst;
  } grp_t;

  function automatic grp_t grp_of(input logic [CTRL_W-1:0] w, input int base);
    grp_t g;
    g.en    = w[base + OFS_EN];
    g.frz   = w[base + OFS_FRZ];
    g.burst = w[base + OFS_BRST];
    return g;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_ctrl(input grp_t ic, input grp_t dc,
                                                   input logic walloc);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[OFS_EN]             = ic.en;
    w[OFS_FRZ]            = ic.frz;
    w[OFS_BRST]           = ic.burst;
    w[DC_BASE + OFS_EN]   = dc.en;
    w[DC_BASE + OFS_FRZ]  = dc.frz;
    w[DC_BASE + OFS_BRST] = dc.burst;
    w[BIT_WALC]           = walloc;
    return w;
  endfunction

endpackage

// File: rtl/ccr_regs.sv
module ccr_regs
  import ccr_pkg::*;
#(
  parameter int IDX_LSB = 4,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output grp_t              ic_grp,
  output grp_t              dc_grp,
  output logic              walloc,
  output logic [1:0]        inv_all,
  output logic [1:0]        inv_one,
  output logic [IDX_W-1:0]  inv_idx
);

  logic [CTRL_W-1:0] addr_q;
  logic              ctrl_wr;
  logic              addr_wr;
  logic [1:0]        cmd_all;
  logic [1:0]        cmd_one;

  assign ctrl_wr = reg_we && !reg_sel;
  assign addr_wr = reg_we && reg_sel;
  assign cmd_all = {reg_wdata[DC_BASE + OFS_ALL], reg_wdata[OFS_ALL]};
  assign cmd_one = {reg_wdata[DC_BASE + OFS_ONE], reg_wdata[OFS_ONE]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_grp  <= '0;
      dc_grp  <= '0;
      walloc  <= 1'b0;
      addr_q  <= '0;
      inv_all <= '0;
      inv_one <= '0;
      inv_idx <= '0;
    end else begin
      inv_all <= ctrl_wr ? cmd_all : 2'b00;
      inv_one <= ctrl_wr ? cmd_one : 2'b00;
      if (ctrl_wr) begin
        ic_grp  <= grp_of(reg_wdata, 0);
        dc_grp  <= grp_of(reg_wdata, DC_BASE);
        walloc  <= reg_wdata[BIT_WALC];
        inv_idx <= addr_q[IDX_LSB +: IDX_W];
      end
      if (addr_wr) addr_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? addr_q : pack_ctrl(ic_grp, dc_grp, walloc);

endmodule

// File: rtl/ccr_valid_array.sv
module ccr_valid_array #(
  parameter int LINES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             alloc_req,
  input  logic             alloc_ok,
  input  logic [IDX_W-1:0] alloc_idx,
  output logic [LINES-1:0] valid
);

  logic             alloc_fire;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] clr_vec;

  assign alloc_fire = alloc_req && alloc_ok;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign set_vec[i] = alloc_fire && (alloc_idx == IDX_W'(i));
    assign clr_vec[i] = inv_all || (inv_one && (inv_idx == IDX_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= (valid | set_vec) & ~clr_vec;
  end

endmodule

// File: rtl/split_cache_ctrl.sv
module split_cache_ctrl
  import ccr_pkg::*;
#(
  parameter int LINES   = 16,
  parameter int IDX_LSB = 4,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ic_alloc_req,
  input  logic [IDX_W-1:0] ic_alloc_idx,
  input  logic             dc_alloc_req,
  input  logic [IDX_W-1:0] dc_alloc_idx,
  output logic             ic_enable,
  output logic             ic_freeze,
  output logic             ic_burst,
  output logic             dc_enable,
  output logic             dc_freeze,
  output logic             dc_burst,
  output logic             dc_wr_alloc,
  output logic             ic_inv_all,
  output logic             dc_inv_all,
  output logic             ic_inv_one,
  output logic             dc_inv_one,
  output logic [LINES-1:0] ic_valid,
  output logic [LINES-1:0] dc_valid
);

  grp_t             ic_grp;
  grp_t             dc_grp;
  logic             walloc;
  logic [1:0]       inv_all;
  logic [1:0]       inv_one;
  logic [IDX_W-1:0] inv_idx;
  grp_t             grp_v   [2];
  logic             req_v   [2];
  logic [IDX_W-1:0] aidx_v  [2];
  logic [LINES-1:0] valid_v [2];

  ccr_regs #(.IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ic_grp(ic_grp),
    .dc_grp(dc_grp), .walloc(walloc), .inv_all(inv_all),
    .inv_one(inv_one), .inv_idx(inv_idx)
  );

  assign grp_v[0]  = ic_grp;
  assign grp_v[1]  = dc_grp;
  assign req_v[0]  = ic_alloc_req;
  assign req_v[1]  = dc_alloc_req;
  assign aidx_v[0] = ic_alloc_idx;
  assign aidx_v[1] = dc_alloc_idx;

  for (genvar c = 0; c < 2; c++) begin : g_cache
    ccr_valid_array #(.LINES(LINES), .IDX_W(IDX_W)) u_valid (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all[c]), .inv_one(inv_one[c]),
      .inv_idx(inv_idx), .alloc_req(req_v[c]),
      .alloc_ok(grp_v[c].en && !grp_v[c].frz), .alloc_idx(aidx_v[c]),
      .valid(valid_v[c])
    );
  end

  assign ic_enable   = ic_grp.en;
  assign ic_freeze   = ic_grp.frz;
  assign ic_burst    = ic_grp.burst;
  assign dc_enable   = dc_grp.en;
  assign dc_freeze   = dc_grp.frz;
  assign dc_burst    = dc_grp.burst;
  assign dc_wr_alloc = walloc;
  assign ic_inv_all  = inv_all[0];
  assign dc_inv_all  = inv_all[1];
  assign ic_inv_one  = inv_one[0];
  assign dc_inv_one  = inv_one[1];
  assign ic_valid    = valid_v[0];
  assign dc_valid    = valid_v[1];

endmodule

// File: rtl/split_cache_ctrl_chk.sv
module split_cache_ctrl_chk #(
  parameter int LINES   = 16,
  parameter int IDX_LSB = 4,
  localparam int IDX_W  = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             ic_alloc_req,
  input logic [IDX_W-1:0] ic_alloc_idx,
  input logic             dc_alloc_req,
  input logic [IDX_W-1:0] dc_alloc_idx,
  input logic             ic_enable,
  input logic             ic_freeze,
  input logic             dc_enable,
  input logic             dc_freeze,
  input logic             ic_inv_all,
  input logic             dc_inv_all,
  input logic             ic_inv_one,
  input logic             dc_inv_one,
  input logic [LINES-1:0] ic_valid,
  input logic [LINES-1:0] dc_valid
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[31:14] == '0) && (reg_rdata[7:5] == '0)); // R2
  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[3:2] == 2'b00) && (reg_rdata[11:10] == 2'b00)); // R3
  AST_IC_ALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ic_inv_all |-> $past(reg_we && !reg_sel && reg_wdata[3])); // R5
  AST_IC_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ic_inv_all |=> (ic_valid == '0)); // R5
  AST_DC_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dc_inv_all |=> (dc_valid == '0)); // R6
  AST_IC_ONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_inv_one && !ic_inv_all) |=> ($countones($past(ic_valid) & ~ic_valid) <= 1)); // R7
  AST_DC_ONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_inv_one && !dc_inv_all) |=> ($countones($past(dc_valid) & ~dc_valid) <= 1)); // R7
  AST_IC_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (!ic_enable || ic_freeze) |=> ((ic_valid & ~$past(ic_valid)) == '0)); // R8
  AST_DC_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_enable || dc_freeze) |=> ((dc_valid & ~$past(dc_valid)) == '0)); // R9

endmodule

bind split_cache_ctrl split_cache_ctrl_chk #(.LINES(LINES), .IDX_LSB(IDX_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ic_alloc_req(ic_alloc_req),
  .ic_alloc_idx(ic_alloc_idx), .dc_alloc_req(dc_alloc_req),
  .dc_alloc_idx(dc_alloc_idx), .ic_enable(ic_enable), .ic_freeze(ic_freeze),
  .dc_enable(dc_enable), .dc_freeze(dc_freeze), .ic_inv_all(ic_inv_all),
  .dc_inv_all(dc_inv_all), .ic_inv_one(ic_inv_one), .dc_inv_one(dc_inv_one),
  .ic_valid(ic_valid), .dc_valid(dc_valid)
);

// File: tb/split_cache_ctrl_tb.sv
module split_cache_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ic_alloc_req = 1'b0;
  logic [3:0]  ic_alloc_idx = '0;
  logic        dc_alloc_req = 1'b0;
  logic [3:0]  dc_alloc_idx = '0;
  logic        ic_enable, ic_freeze, ic_burst;
  logic        dc_enable, dc_freeze, dc_burst, dc_wr_alloc;
  logic        ic_inv_all, dc_inv_all, ic_inv_one, dc_inv_one;
  logic [15:0] ic_valid, dc_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ic_alloc_req(ic_alloc_req), .ic_alloc_idx(ic_alloc_idx),
    .dc_alloc_req(dc_alloc_req), .dc_alloc_idx(dc_alloc_idx),
    .ic_enable(ic_enable), .ic_freeze(ic_freeze), .ic_burst(ic_burst),
    .dc_enable(dc_enable), .dc_freeze(dc_freeze), .dc_burst(dc_burst),
    .dc_wr_alloc(dc_wr_alloc), .ic_inv_all(ic_inv_all), .dc_inv_all(dc_inv_all),
    .ic_inv_one(ic_inv_one), .dc_inv_one(dc_inv_one),
    .ic_valid(ic_valid), .dc_valid(dc_valid)
  );

  // {written word, expected read-back}
  localparam logic [63:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'h0000_3313},
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_2100, 32'h0000_2100},
    {32'h0000_0FFC, 32'h0000_0310},
    {32'h1234_5678, 32'h0000_1210},
    {32'h0000_E0E0, 32'h0000_2000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic alloc(input logic ic, input logic dc, input logic [3:0] idx);
    ic_alloc_req = ic; dc_alloc_req = dc; ic_alloc_idx = idx; dc_alloc_idx = idx;
    @(negedge clk);
    ic_alloc_req = 1'b0; dc_alloc_req = 1'b0;
  endtask

  function automatic logic [31:0] levels();
    return {18'b0, dc_wr_alloc, dc_burst, 2'b0, dc_freeze, dc_enable,
            3'b0, ic_burst, 2'b0, ic_freeze, ic_enable};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset();
    reg_sel = 1'b0; #1;
    check("R4 ctrl", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    check("R4 addr", reg_rdata, 32'h0);
    reg_sel = 1'b0;
    check("R4 levels", levels(), 32'h0);
    check("R4 strobes", {28'b0, ic_inv_all, dc_inv_all, ic_inv_one, dc_inv_one}, 32'h0);
    check("R4 valid", {ic_valid, dc_valid}, 32'h0);
  endtask

  initial begin
    do_reset();
    check_reset();

    // R1 R2 R3 R12: table walk of control writes
    foreach (VEC[i]) begin
      wr(1'b0, VEC[i][63:32]);
      #1;
      check("R1/R2/R3 readback", reg_rdata, VEC[i][31:0]);
      check("R12 levels", levels(), VEC[i][31:0]);
    end

    // R11 address register
    wr(1'b1, 32'hDEAD_BEEF);
    reg_sel = 1'b1; #1;
    check("R11 addr readback", reg_rdata, 32'hDEAD_BEEF);
    reg_sel = 1'b0;

    // R8 fill both caches when enabled
    wr(1'b0, 32'h0000_0101);
    @(negedge clk);
    for (int k = 0; k < 16; k++) alloc(1'b1, 1'b1, 4'(k));
    check("R8 fill", {ic_valid, dc_valid}, 32'hFFFF_FFFF);

    // R7 single-line clears
    wr(1'b1, 32'h0000_0050);
    wr(1'b0, 32'h0000_0105);
    check("R7 ic strobe", {30'b0, ic_inv_one, dc_inv_one}, 32'h2);
    wr(1'b1, 32'h0000_00A0); // later address write must not move the pending index
    check("R7 ic one line", {ic_valid, dc_valid}, 32'hFFDF_FFFF);
    wr(1'b0, 32'h0000_0501);
    #1;
    check("R3 clear-entry reads 0", reg_rdata, 32'h0000_0101);
    @(negedge clk);
    check("R7 dc one line", {ic_valid, dc_valid}, 32'hFFDF_FBFF);

    // R5 instruction clear-all, one-cycle strobe
    wr(1'b0, 32'h0000_0109);
    check("R5 strobe", {30'b0, ic_inv_all, dc_inv_all}, 32'h2);
    @(negedge clk);
    check("R5 strobe drops", {31'b0, ic_inv_all}, 32'h0);
    check("R5 ic cleared dc kept", {ic_valid, dc_valid}, 32'h0000_FBFF);

    // R6 both clear-all together
    for (int k = 0; k < 16; k++) alloc(1'b1, 1'b0, 4'(k));
    wr(1'b0, 32'h0000_0909);
    check("R6 both strobes", {30'b0, ic_inv_all, dc_inv_all}, 32'h3);
    @(negedge clk);
    check("R6 both cleared", {ic_valid, dc_valid}, 32'h0);

    // R9 freeze blocks allocation
    wr(1'b0, 32'h0000_0303);
    alloc(1'b1, 1'b1, 4'd2);
    check("R9 frozen no alloc", {ic_valid, dc_valid}, 32'h0);
    wr(1'b0, 32'h0000_0101);
    ic_alloc_req = 1'b1; ic_alloc_idx = 4'd2;
    dc_alloc_req = 1'b1; dc_alloc_idx = 4'd7;
    @(negedge clk);
    ic_alloc_req = 1'b0; dc_alloc_req = 1'b0;
    check("R8 unfrozen alloc", {ic_valid, dc_valid}, 32'h0004_0080);
    wr(1'b0, 32'h0000_0B0B);
    @(negedge clk);
    check("R9 clear while frozen", {ic_valid, dc_valid}, 32'h0);
    check("R9 freeze kept", levels(), 32'h0000_0303);

    // R8 disabled cache does not allocate
    wr(1'b0, 32'h0000_0000);
    alloc(1'b1, 1'b1, 4'd1);
    check("R8 disabled no alloc", {ic_valid, dc_valid}, 32'h0);

    // R10 invalidate beats same-edge allocation
    wr(1'b0, 32'h0000_0101);
    alloc(1'b1, 1'b0, 4'd6);
    wr(1'b0, 32'h0000_0109);
    alloc(1'b1, 1'b0, 4'd9);
    check("R10 clear-all wins", ic_valid, 16'h0);
    wr(1'b1, 32'h0000_0030);
    wr(1'b0, 32'h0000_0105);
    alloc(1'b1, 1'b0, 4'd3);
    check("R10 clear-entry wins", ic_valid, 16'h0);

    // R4 reset in mid-run
    alloc(1'b1, 1'b1, 4'd4);
    wr(1'b1, 32'h0000_1234);
    wr(1'b0, 32'h0000_3313);
    do_reset();
    check_reset();

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule